// File: doc/BRIEF.md
# Dual-Address Access and Write-Guard Decoder

This block sits behind a 2-wire slave front end. The front end reports events as one-cycle pulses: a received address byte (7-bit device address plus the read/write bit), a received data byte, a finished read byte and a STOP condition. From these events the block decides four things. It decides whether the transaction is answered at all. It maps the byte pointer onto a memory region: the auxiliary bank, the lower main half, or one of the upper-half pages chosen by a page-select byte. It decides whether each written byte may reach memory. It decides when a nonvolatile commit should begin.

The block answers two device addresses. The auxiliary address is fixed at 7'h50, which is A0h on the wire. The main address is either a default of 7'h51 (A2h on the wire) or a programmed 7-bit value. Writes through the main address are guarded by the product of a pin and a configuration bit. Writes through the auxiliary address are guarded by a second bit alone. The main scratch window 60h..7Fh is never guarded.

A merged mode (`aden_i`=1) silences the auxiliary address. In that mode page 00 of the main upper half is guarded by the auxiliary bit only.

The controller has five states:
- `ST_IDLE`: the state after reset or STOP.
- `ST_IGNORE`: the transaction is not addressed to this block.
- `ST_OFFSET`: a write address has been answered and the next byte is the pointer.
- `ST_WRITE`: data bytes are being received.
- `ST_READ`: data bytes are being sent.

The transitions are:
- `go_stop`: any state returns to `ST_IDLE` on STOP.
- `go_miss`: an unmatched address leads to `ST_IGNORE`.
- `go_wr_hit`: a matched address with write leads to `ST_OFFSET`.
- `go_rd_hit`: a matched address with read leads to `ST_READ`.
- `go_ptr_set`: the pointer byte moves `ST_OFFSET` to `ST_WRITE`.

An address byte may arrive in any state, which is how a repeated START is handled.

Top module: `dual_addr_access`

## Requirements
- R1: Address 7'h50 is acknowledged when `aden_i`=0 and is not acknowledged when `aden_i`=1, unless it equals the main address.
- R2: The main address is 7'h51 when `adfix_i`=0. It is `prog_dev_addr_i` when `adfix_i`=1, and 7'h51 is then not acknowledged. A matched read or write address gives `ack_o`=1 in the cycle after the address pulse.
- R3: After an unmatched address, `ack_o` stays 0 and no write is issued for any following data byte until the next address or STOP.
- R4: The first data byte after a write address loads the 8-bit pointer. Each further data byte writes at the pointer, then the pointer increments in its low 7 bits while bit 7 is held, so it wraps within its 128-byte half (FE, FF, 80).
- R5: Region encoding is `acc_region_o`/`wr_region_o`: 0 for main with pointer bit 7 = 0, 1 for main with pointer bit 7 = 1, and 2 for auxiliary. The table output equals `tbl_sel_i` for region 1 and is 0 otherwise.
- R6: A main write outside 60h..7Fh is blocked exactly when `wpen_i`=1 and `mpen_i`=1, except for the case covered by R9.
- R7: A main write to 60h..7Fh is never blocked, whatever the values of `apen_i`, `mpen_i` and `wpen_i`.
- R8: An auxiliary write is blocked exactly when `apen_i`=1, regardless of `wpen_i` and `mpen_i`.
- R9: With `aden_i`=1, a main write to the upper half with `tbl_sel_i`=0 is blocked exactly when `apen_i`=1; `wpen_i` and `mpen_i` have no effect on it.
- R10: A blocked data byte is still acknowledged (`ack_o`=1) but raises no `wr_en_o`, and the pointer still advances. An accepted byte raises `wr_en_o` for one cycle together with its region, table, pointer and data.
- R11: `commit_o` pulses one cycle after STOP exactly when at least one accepted write outside main 60h..7Fh occurred since the previous STOP.
- R12: A matched read address is acknowledged even when writes are guarded. Each read-done pulse in `ST_READ` advances the pointer with the same wrap as R4.
- R13: After reset, `ack_o`, `wr_en_o` and `commit_o` are 0, the pointer is 00h and region 0 is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_valid_i | input | 1 | Address byte received (pulse) |
| dev_addr_i | input | 7 | Received 7-bit device address |
| rw_i | input | 1 | 1 = read, 0 = write |
| byte_valid_i | input | 1 | Data byte received from the master (pulse) |
| byte_i | input | 8 | Received data byte |
| rd_done_i | input | 1 | A read byte was sent (pulse) |
| stop_i | input | 1 | STOP condition seen (pulse) |
| aden_i | input | 1 | Merged mode: auxiliary address silent, page 00 under auxiliary guard |
| adfix_i | input | 1 | Use programmed main address |
| apen_i | input | 1 | Auxiliary write guard bit |
| mpen_i | input | 1 | Main write guard bit |
| wpen_i | input | 1 | Write-guard pin |
| prog_dev_addr_i | input | 7 | Programmed main address (upper seven bits of the address byte) |
| tbl_sel_i | input | 8 | Page select for the main upper half |
| ack_o | output | 1 | Acknowledge for the last address or written byte |
| acc_region_o | output | 2 | Region of the current pointer |
| acc_table_o | output | 8 | Page of the current pointer |
| acc_off_o | output | 8 | Current byte pointer |
| wr_en_o | output | 1 | Accepted write strobe |
| wr_region_o | output | 2 | Region of the write |
| wr_table_o | output | 8 | Page of the write |
| wr_off_o | output | 8 | Byte offset of the write |
| wr_data_o | output | 8 | Write data |
| commit_o | output | 1 | Start nonvolatile commit |

## Verification
The hardest case to reach is the commit decision at STOP. It depends on the whole history of the transaction, not on the last byte. A transaction whose only accepted writes land in the scratch window must not commit, and one whose nonvolatile writes were all blocked must not commit either. The stimulus therefore builds complete transactions under chosen guard settings: some mixing blocked and scratch writes, others containing a single accepted nonvolatile byte. Each transaction is closed with STOP and the pulse one cycle later is compared. Page 00 under merged mode is reached by switching `aden_i` and `tbl_sel_i` between transactions, with `wpen_i` and `mpen_i` held in the opposite state, so that a wrong guard choice shows at `wr_en_o`.

// File: rtl/dacc_pkg.sv
package dacc_pkg;
    typedef enum logic [1:0] {
        RG_MAIN_LO = 2'd0,
        RG_TABLE   = 2'd1,
        RG_AUX     = 2'd2
    } region_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OFFSET,
        ST_WRITE,
        ST_READ,
        ST_IGNORE
    } state_e;
endpackage

// File: rtl/dacc_addr_match.sv
module dacc_addr_match #(
    parameter int          DEV_W    = 7,
    parameter logic [6:0]  AUX_ADDR = 7'h50,
    parameter logic [6:0]  MAIN_DEF = 7'h51
) (
    input  logic [DEV_W-1:0] dev_addr_i,
    input  logic             aden_i,
    input  logic             adfix_i,
    input  logic [DEV_W-1:0] prog_dev_addr_i,
    output logic             hit_o,
    output logic             is_main_o
);
    logic [DEV_W-1:0] main_addr;
    logic             main_hit;
    logic             aux_hit;

    always_comb begin
        main_addr = adfix_i ? prog_dev_addr_i : MAIN_DEF;
        main_hit  = (dev_addr_i == main_addr);
        aux_hit   = !aden_i && (dev_addr_i == AUX_ADDR);
        hit_o     = main_hit || aux_hit;
        is_main_o = main_hit;
    end
endmodule

// File: rtl/dacc_wp_decode.sv
module dacc_wp_decode
    import dacc_pkg::*;
#(
    parameter int             OFS_W  = 8,
    parameter int             TBL_W  = 8,
    parameter logic [OFS_W-1:0] SCR_LO = 8'h60,
    parameter logic [OFS_W-1:0] SCR_HI = 8'h7F
) (
    input  logic             is_main_i,
    input  logic [OFS_W-1:0] off_i,
    input  logic [TBL_W-1:0] tbl_sel_i,
    input  logic             aden_i,
    input  logic             apen_i,
    input  logic             mpen_i,
    input  logic             wpen_i,
    output region_e          region_o,
    output logic [TBL_W-1:0] table_o,
    output logic             volatile_o,
    output logic             blocked_o
);
    localparam int UP_BIT = OFS_W - 1;

    logic upper;
    logic merged_page0;

    always_comb begin
        upper        = off_i[UP_BIT];
        merged_page0 = is_main_i && upper && aden_i && (tbl_sel_i == '0);
        volatile_o   = is_main_i && !upper && (off_i >= SCR_LO) && (off_i <= SCR_HI);

        if (!is_main_i)      region_o = RG_AUX;
        else if (upper)      region_o = RG_TABLE;
        else                 region_o = RG_MAIN_LO;

        table_o = (is_main_i && upper) ? tbl_sel_i : '0;

        if (!is_main_i)        blocked_o = apen_i;
        else if (volatile_o)   blocked_o = 1'b0;
        else if (merged_page0) blocked_o = apen_i;
        else                   blocked_o = wpen_i && mpen_i;
    end
endmodule

// File: rtl/dual_addr_access.sv
module dual_addr_access
    import dacc_pkg::*;
#(
    parameter int               DEV_W    = 7,
    parameter int               OFS_W    = 8,
    parameter int               DATA_W   = 8,
    parameter int               TBL_W    = 8,
    parameter logic [6:0]       AUX_ADDR = 7'h50,
    parameter logic [6:0]       MAIN_DEF = 7'h51,
    parameter logic [OFS_W-1:0] SCR_LO   = 8'h60,
    parameter logic [OFS_W-1:0] SCR_HI   = 8'h7F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_valid_i,
    input  logic [DEV_W-1:0]  dev_addr_i,
    input  logic              rw_i,
    input  logic              byte_valid_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic              rd_done_i,
    input  logic              stop_i,
    input  logic              aden_i,
    input  logic              adfix_i,
    input  logic              apen_i,
    input  logic              mpen_i,
    input  logic              wpen_i,
    input  logic [DEV_W-1:0]  prog_dev_addr_i,
    input  logic [TBL_W-1:0]  tbl_sel_i,
    output logic              ack_o,
    output logic [1:0]        acc_region_o,
    output logic [TBL_W-1:0]  acc_table_o,
    output logic [OFS_W-1:0]  acc_off_o,
    output logic              wr_en_o,
    output logic [1:0]        wr_region_o,
    output logic [TBL_W-1:0]  wr_table_o,
    output logic [OFS_W-1:0]  wr_off_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              commit_o
);
    localparam int               LO_W   = OFS_W - 1;
    localparam logic [LO_W-1:0]  LO_ONE = 1;

    state_e             state_q, state_d;
    logic [OFS_W-1:0]   ptr_q;
    logic [OFS_W-1:0]   ptr_step;
    logic               main_sel_q;
    logic               pend_q;
    logic               hit;
    logic               hit_main;
    region_e            cur_region;
    logic [TBL_W-1:0]   cur_table;
    logic               cur_volatile;
    logic               cur_blocked;
    logic               data_evt;

    dacc_addr_match #(
        .DEV_W    (DEV_W),
        .AUX_ADDR (AUX_ADDR),
        .MAIN_DEF (MAIN_DEF)
    ) u_match (
        .dev_addr_i      (dev_addr_i),
        .aden_i          (aden_i),
        .adfix_i         (adfix_i),
        .prog_dev_addr_i (prog_dev_addr_i),
        .hit_o           (hit),
        .is_main_o       (hit_main)
    );

    dacc_wp_decode #(
        .OFS_W  (OFS_W),
        .TBL_W  (TBL_W),
        .SCR_LO (SCR_LO),
        .SCR_HI (SCR_HI)
    ) u_guard (
        .is_main_i  (main_sel_q),
        .off_i      (ptr_q),
        .tbl_sel_i  (tbl_sel_i),
        .aden_i     (aden_i),
        .apen_i     (apen_i),
        .mpen_i     (mpen_i),
        .wpen_i     (wpen_i),
        .region_o   (cur_region),
        .table_o    (cur_table),
        .volatile_o (cur_volatile),
        .blocked_o  (cur_blocked)
    );

    assign ptr_step = {ptr_q[OFS_W-1], ptr_q[LO_W-1:0] + LO_ONE};
    assign data_evt = byte_valid_i && !stop_i && !addr_valid_i;

    // next-state selection
    always_comb begin
        state_d = state_q;
        if (stop_i) begin
            state_d = ST_IDLE;
        end else if (addr_valid_i) begin
            if (!hit)      state_d = ST_IGNORE;
            else if (rw_i) state_d = ST_READ;
            else           state_d = ST_OFFSET;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_OFFSET: state_d = byte_valid_i ? ST_WRITE : ST_OFFSET;
                ST_WRITE:  state_d = ST_WRITE;
                ST_READ:   state_d = ST_READ;
                ST_IGNORE: state_d = ST_IGNORE;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_o       <= 1'b0;
            wr_en_o     <= 1'b0;
            wr_region_o <= '0;
            wr_table_o  <= '0;
            wr_off_o    <= '0;
            wr_data_o   <= '0;
            commit_o    <= 1'b0;
            pend_q      <= 1'b0;
            ptr_q       <= '0;
            main_sel_q  <= 1'b1;
        end else begin
            ack_o    <= 1'b0;
            wr_en_o  <= 1'b0;
            commit_o <= 1'b0;
            if (stop_i) begin
                commit_o <= pend_q;
                pend_q   <= 1'b0;
            end else if (addr_valid_i) begin
                ack_o <= hit;
                if (hit) main_sel_q <= hit_main;
            end else if (byte_valid_i) begin
                unique case (state_q)
                    ST_OFFSET: begin
                        ack_o <= 1'b1;
                        ptr_q <= byte_i[OFS_W-1:0];
                    end
                    ST_WRITE: begin
                        ack_o       <= 1'b1;
                        wr_en_o     <= !cur_blocked;
                        wr_region_o <= cur_region;
                        wr_table_o  <= cur_table;
                        wr_off_o    <= ptr_q;
                        wr_data_o   <= byte_i;
                        if (!cur_blocked && !cur_volatile) pend_q <= 1'b1;
                        ptr_q       <= ptr_step;
                    end
                    ST_IDLE, ST_READ, ST_IGNORE: ack_o <= 1'b0;
                    default: ack_o <= 1'b0;
                endcase
            end else if (rd_done_i && state_q == ST_READ) begin
                ptr_q <= ptr_step;
            end
        end
    end

    assign acc_region_o = cur_region;
    assign acc_table_o  = cur_table;
    assign acc_off_o    = ptr_q;

    // R1: silenced auxiliary address gets no acknowledge
    assert_aux_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid_i && !stop_i && aden_i && dev_addr_i == AUX_ADDR &&
         !(adfix_i && prog_dev_addr_i == AUX_ADDR)) |=> !ack_o);

    // R3: unaddressed transaction stays silent
    assert_ignore_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IGNORE && data_evt) |=> (!ack_o && !wr_en_o));

    // R4: pointer half bit held across a written byte
    assert_ptr_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITE && data_evt) |=> (ptr_q[OFS_W-1] == $past(ptr_q[OFS_W-1])));

    // R7: scratch window writes always go through
    assert_scratch_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITE && data_evt && main_sel_q &&
         ptr_q >= SCR_LO && ptr_q <= SCR_HI) |=> wr_en_o);

    // R10: write strobe only answers a received data byte
    assert_wr_from_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> $past(byte_valid_i));

    // R11: commit only right after STOP
    assert_commit_after_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> $past(stop_i));
endmodule

// File: tb/sim_dual_addr_access.sv
module sim_dual_addr_access;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_valid = 0, rw = 0, byte_valid = 0, rd_done = 0, stop = 0;
    logic [6:0] dev_addr = '0;
    logic [7:0] byte_d = '0;
    logic       aden = 0, adfix = 0, apen = 0, mpen = 0, wpen = 0;
    logic [6:0] prog_addr = 7'h5A;
    logic [7:0] tbl_sel = 8'h01;
    logic       ack_o, wr_en_o, commit_o;
    logic [1:0] acc_region_o, wr_region_o;
    logic [7:0] acc_table_o, acc_off_o, wr_table_o, wr_off_o, wr_data_o;

    int n_chk = 0;
    int n_fail = 0;
    logic [25:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_addr_access u0 (
        .clk(clk), .rst_n(rst_n),
        .addr_valid_i(addr_valid), .dev_addr_i(dev_addr), .rw_i(rw),
        .byte_valid_i(byte_valid), .byte_i(byte_d), .rd_done_i(rd_done), .stop_i(stop),
        .aden_i(aden), .adfix_i(adfix), .apen_i(apen), .mpen_i(mpen), .wpen_i(wpen),
        .prog_dev_addr_i(prog_addr), .tbl_sel_i(tbl_sel),
        .ack_o(ack_o), .acc_region_o(acc_region_o), .acc_table_o(acc_table_o),
        .acc_off_o(acc_off_o), .wr_en_o(wr_en_o), .wr_region_o(wr_region_o),
        .wr_table_o(wr_table_o), .wr_off_o(wr_off_o), .wr_data_o(wr_data_o),
        .commit_o(commit_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic send_addr(input logic [6:0] a, input bit r, input bit exp_ack, input string req);
        @(negedge clk); dev_addr = a; rw = r; addr_valid = 1;
        @(negedge clk); addr_valid = 0;
        chk(ack_o == exp_ack, req, ack_o, exp_ack);
    endtask

    task automatic send_ptr(input logic [7:0] p, input string req);
        @(negedge clk); byte_d = p; byte_valid = 1;
        @(negedge clk); byte_valid = 0;
        chk(ack_o == 1'b1 && acc_off_o == p, req, acc_off_o, p);
    endtask

    task automatic send_data(input logic [7:0] d, input bit exp_ack, input bit exp_wr,
                             input logic [1:0] rg, input logic [7:0] tb, input logic [7:0] of,
                             input string req);
        if (exp_wr) exp_q.push_back({rg, tb, of, d});
        @(negedge clk); byte_d = d; byte_valid = 1;
        @(negedge clk); byte_valid = 0;
        chk(ack_o == exp_ack, {req, " ack"}, ack_o, exp_ack);
        chk(wr_en_o == exp_wr, {req, " wr_en"}, wr_en_o, exp_wr);
    endtask

    task automatic send_stop(input bit exp_commit, input string req);
        @(negedge clk); stop = 1;
        @(negedge clk); stop = 0;
        chk(commit_o == exp_commit, req, commit_o, exp_commit);
    endtask

    task automatic read_next(input logic [7:0] exp_off, input string req);
        @(negedge clk); rd_done = 1;
        @(negedge clk); rd_done = 0;
        chk(acc_off_o == exp_off, req, acc_off_o, exp_off);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && wr_en_o) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected write", {wr_region_o, wr_table_o, wr_off_o, wr_data_o}, 0);
            end else begin
                logic [25:0] e;
                e = exp_q.pop_front();
                chk({wr_region_o, wr_table_o, wr_off_o, wr_data_o} == e, "R10 write item",
                    {wr_region_o, wr_table_o, wr_off_o, wr_data_o}, e);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        chk(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R13 reset state
        chk(ack_o == 0 && wr_en_o == 0 && commit_o == 0, "R13 outputs idle", {ack_o, wr_en_o, commit_o}, 0);
        chk(acc_off_o == 0 && acc_region_o == 0, "R13 pointer", acc_off_o, 0);
        rst_n = 1;
        @(negedge clk);

        // R2 default main address, R5 lower region, R11 commit
        send_addr(7'h51, 0, 1, "R2 main default");
        send_ptr(8'h10, "R4 pointer load");
        chk(acc_region_o == 0 && acc_table_o == 0, "R5 lower main", acc_region_o, 0);
        send_data(8'hAA, 1, 1, 2'd0, 8'h00, 8'h10, "R10 main write");
        send_data(8'hBB, 1, 1, 2'd0, 8'h00, 8'h11, "R4 increment");
        send_stop(1, "R11 commit after nv write");

        // R4 wrap in upper half, R5 page select
        send_addr(7'h51, 0, 1, "R2 main again");
        send_ptr(8'hFE, "R4 upper pointer");
        chk(acc_region_o == 1 && acc_table_o == 8'h01, "R5 page region", acc_table_o, 1);
        send_data(8'h01, 1, 1, 2'd1, 8'h01, 8'hFE, "R5 page write");
        send_data(8'h02, 1, 1, 2'd1, 8'h01, 8'hFF, "R4 top byte");
        send_data(8'h03, 1, 1, 2'd1, 8'h01, 8'h80, "R4 wrap to 80");
        chk(acc_off_o == 8'h81, "R4 after wrap", acc_off_o, 8'h81);
        send_stop(1, "R11 commit page");

        // R1 auxiliary answered, R5 aux region
        send_addr(7'h50, 0, 1, "R1 aux answered");
        send_ptr(8'h85, "R4 aux pointer");
        chk(acc_region_o == 2 && acc_table_o == 0, "R5 aux region", acc_region_o, 2);
        send_data(8'h5C, 1, 1, 2'd2, 8'h00, 8'h85, "R8 aux open");
        send_stop(1, "R11 aux commit");

        // R1 merged mode silences aux, R3 ignored bytes
        aden = 1;
        send_addr(7'h50, 0, 0, "R1 aux silent");
        send_data(8'h77, 0, 0, 2'd0, 8'h00, 8'h00, "R3 ignored byte");
        send_data(8'h78, 0, 0, 2'd0, 8'h00, 8'h00, "R3 ignored byte 2");
        send_stop(0, "R11 no commit when ignored");
        aden = 0;
        send_addr(7'h33, 0, 0, "R3 foreign address");
        send_stop(0, "R3 no commit");

        // R2 programmed address
        adfix = 1;
        send_addr(7'h51, 0, 0, "R2 default unused");
        send_addr(7'h5A, 0, 1, "R2 programmed");
        send_ptr(8'h20, "R4 pointer");
        send_data(8'h9D, 1, 1, 2'd0, 8'h00, 8'h20, "R2 write via programmed");
        send_stop(1, "R11 commit");
        adfix = 0;

        // R6 main guard, R10 blocked still acked, R7 scratch open
        wpen = 1; mpen = 1;
        send_addr(7'h51, 0, 1, "R12 ack under guard");
        send_ptr(8'h30, "R4 pointer");
        send_data(8'h11, 1, 0, 2'd0, 8'h00, 8'h30, "R6 lower blocked");
        chk(acc_off_o == 8'h31, "R10 pointer advances", acc_off_o, 8'h31);
        send_addr(7'h51, 0, 1, "R2 restart");
        send_ptr(8'h90, "R4 pointer");
        send_data(8'h12, 1, 0, 2'd1, 8'h01, 8'h90, "R6 page blocked");
        send_addr(7'h51, 0, 1, "R2 restart");
        send_ptr(8'h60, "R4 pointer");
        apen = 1;
        send_data(8'h13, 1, 1, 2'd0, 8'h00, 8'h60, "R7 scratch open");
        send_data(8'h14, 1, 1, 2'd0, 8'h00, 8'h61, "R7 scratch open 2");
        send_stop(0, "R11 no commit for scratch/blocked");
        apen = 0;

        // R6 one guard alone does not block
        mpen = 0;
        send_addr(7'h51, 0, 1, "R2");
        send_ptr(8'h40, "R4 pointer");
        send_data(8'h15, 1, 1, 2'd0, 8'h00, 8'h40, "R6 pin alone open");
        send_stop(1, "R11 commit");
        wpen = 0; mpen = 1;
        send_addr(7'h51, 0, 1, "R2");
        send_ptr(8'h41, "R4 pointer");
        send_data(8'h16, 1, 1, 2'd0, 8'h00, 8'h41, "R6 bit alone open");
        send_stop(1, "R11 commit");

        // R8 aux guard
        apen = 1; wpen = 0; mpen = 0;
        send_addr(7'h50, 0, 1, "R1 aux");
        send_ptr(8'h06, "R4 pointer");
        send_data(8'h17, 1, 0, 2'd2, 8'h00, 8'h06, "R8 aux blocked");
        send_stop(0, "R11 blocked no commit");
        apen = 0; wpen = 1; mpen = 1;
        send_addr(7'h50, 0, 1, "R1 aux");
        send_ptr(8'h07, "R4 pointer");
        send_data(8'h18, 1, 1, 2'd2, 8'h00, 8'h07, "R8 aux ignores pin");
        send_stop(1, "R11 commit");

        // R9 merged page 00 guarded by apen only
        aden = 1; tbl_sel = 8'h00;
        send_addr(7'h51, 0, 1, "R2");
        send_ptr(8'h85, "R4 pointer");
        send_data(8'h19, 1, 1, 2'd1, 8'h00, 8'h85, "R9 page0 open despite pin");
        apen = 1; wpen = 0; mpen = 0;
        send_data(8'h1A, 1, 0, 2'd1, 8'h00, 8'h86, "R9 page0 blocked by apen");
        tbl_sel = 8'h02;
        send_data(8'h1B, 1, 1, 2'd1, 8'h02, 8'h87, "R9 other page open");
        send_stop(1, "R11 commit");
        aden = 0; apen = 0; tbl_sel = 8'h01;

        // R12 read with wrap
        wpen = 1; mpen = 1;
        send_addr(7'h51, 0, 1, "R2");
        send_ptr(8'h7F, "R4 pointer");
        send_addr(7'h51, 1, 1, "R12 read ack");
        chk(acc_off_o == 8'h7F && acc_region_o == 0, "R12 read pointer", acc_off_o, 8'h7F);
        read_next(8'h00, "R12 read wrap");
        read_next(8'h01, "R12 read step");
        send_stop(0, "R11 read no commit");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R10 all expected writes seen", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule